// File: doc/BRIEF.md
# Dual Attenuator Wiper Controller with Zero-Cross Commit

This block is a slave on a two-wire serial bus. It holds the positions of two audio attenuator wipers. The bus master addresses the device and sends a command byte followed by a data byte. The command picks wiper 0, wiper 1, or both wipers. A new position is not applied at once. It is parked as a pending value, and it moves to the wiper output only when that channel's zero-crossing strobe fires. This keeps step changes away from large signal amplitudes. A read transfer returns the two applied positions.

Each wiper has 65 positions. Codes 0 through 63 are attenuation steps of 1 dB, and code 64 is mute. Three strap pins complete the slave address, so eight of these blocks can share one bus. SCL and SDA are sampled on the system clock through two-stage synchronizers. The block drives SDA as an open-drain line: when `sda_oe` is high, the pad pulls SDA low.

Top module: `wiper_ctl_top`

## Requirements
- R1: After reset, both wiper outputs read 64 (mute), nothing is pending, and `sda_oe` is low.
- R2: An address byte whose upper seven bits equal 0101 followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]` is acknowledged. Its bit 0 selects read (1) or write (0). A non-matching address gets no acknowledge, and every byte after it up to the next START is ignored.
- R3: Command 0xA9 loads wiper 0, command 0xAA loads wiper 1, and command 0xAF loads both wipers with the same value. In each case the value comes from the data byte that follows, and it becomes pending.
- R4: A data value above 64 is stored as 64.
- R5: A pending value reaches its wiper output only on a cycle where that channel's bit of `zc_i` is high. The output changes on the clock edge that samples the strobe. Without the strobe, the output holds. The other channel's strobe has no effect on it.
- R6: Once addressed, the slave pulls SDA low for the ninth clock of every byte it receives. It changes `sda_oe` only while SCL is low.
- R7: A read returns the wiper 0 position and then the wiper 1 position. Any further bytes repeat wiper 1. The values are the applied positions, not pending ones. Each byte is sent MSB first, with the position zero-extended to 8 bits.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and stops sending.
- R9: One write transfer can carry any number of command and data byte pairs.
- R10: A START at any point returns the slave to the address phase. A half-finished command is dropped and writes nothing.
- R11: A command byte other than the three listed is still acknowledged, but the data byte that follows it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | 3 | Address straps, low three bits of the 7-bit address |
| zc_i | input | 2 | Zero-crossing strobe per channel (bit 0 is wiper 0) |
| wiper0_o | output | 7 | Applied wiper 0 position, 64 = mute |
| wiper1_o | output | 7 | Applied wiper 1 position, 64 = mute |

## Verification
The bench targets the gap between a pending write and its commit:
- It strobes the wrong channel first. A design that mixed up the per-channel enables would move the wrong wiper.
- It reads back before any strobe. A design that returned pending values would report the new value.

It also covers the edges of the byte protocol:
- A foreign address followed by a full write. A design that did not go deaf until START would act on it.
- A repeated START in the middle of a command. The half-finished command must not write.
- Data values of 64, 65 and 255. A wrong clamp would leak codes above mute.
- An unknown command byte.
- A master NACK. A slave that kept driving would hold SDA low and block the STOP.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_TXACK
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } phase_e;

  localparam logic [7:0] CMD_WIPER0 = 8'hA9;
  localparam logic [7:0] CMD_WIPER1 = 8'hAA;
  localparam logic [7:0] CMD_BOTH   = 8'hAF;

  // channel mask selected by a command byte, zero for unknown commands
  function automatic logic [1:0] cmd_to_mask(input logic [7:0] code);
    logic [1:0] m;
    case (code)
      CMD_WIPER0: m = 2'b01;
      CMD_WIPER1: m = 2'b10;
      CMD_BOTH:   m = 2'b11;
      default:    m = 2'b00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/wiper_line_sync.sv
module wiper_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_p;
  logic              sda_p;
  logic              scl_n;
  logic              sda_n;

  assign scl_n = scl_q[STAGES-1];
  assign sda_n = sda_q[STAGES-1];

  // idle bus is high on both lines
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_n;
      sda_p <= sda_n;
    end
  end

  always_comb begin
    scl_rise  = scl_n & ~scl_p;
    scl_fall  = ~scl_n & scl_p;
    start_det = scl_n & scl_p & sda_p & ~sda_n;
    stop_det  = scl_n & scl_p & ~sda_p & sda_n;
    sda_lvl   = sda_n;
  end

endmodule

// File: rtl/wiper_serial_slave.sv
module wiper_serial_slave
  import wiper_pkg::*;
#(
  parameter int          POS_W       = 7,
  parameter int          MUTE        = 64,
  parameter logic [3:0]  ADDR_PREFIX = 4'b0101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       strap_i,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_lvl,
  input  logic [POS_W-1:0] rd_pos0,
  input  logic [POS_W-1:0] rd_pos1,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [1:0]       wr_mask,
  output logic [POS_W-1:0] wr_val
);

  localparam int         BYTE_W = 8;
  localparam logic [3:0] LAST_RX = 4'(BYTE_W);
  localparam logic [3:0] LAST_TX = 4'(BYTE_W - 1);
  localparam logic [7:0] MUTE_B  = 8'(MUTE);

  bus_state_e        state;
  phase_e            phase;
  logic [3:0]        cnt;
  logic [7:0]        shreg;
  logic [7:0]        txsh;
  logic [1:0]        cmd_mask;
  logic              is_read;
  logic              mack;

  logic              addr_hit;
  logic [POS_W-1:0]  clamped;
  logic [7:0]        tx_first;
  logic [7:0]        tx_next;

  always_comb begin
    addr_hit = (shreg[7:1] == {ADDR_PREFIX, strap_i});
    clamped  = (shreg > MUTE_B) ? POS_W'(MUTE) : shreg[POS_W-1:0];
    tx_first = 8'(rd_pos0);
    tx_next  = 8'(rd_pos1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      phase    <= PH_ADDR;
      cnt      <= '0;
      shreg    <= '0;
      txsh     <= '0;
      cmd_mask <= '0;
      is_read  <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_mask  <= '0;
      wr_val   <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state    <= S_RX;
        phase    <= PH_ADDR;
        cnt      <= '0;
        is_read  <= 1'b0;
        cmd_mask <= '0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && cnt != LAST_RX) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == LAST_RX) begin
              cnt <= '0;
              case (phase)
                PH_ADDR: begin
                  if (addr_hit) begin
                    sda_oe  <= 1'b1;
                    state   <= S_ACK;
                    is_read <= shreg[0];
                    phase   <= PH_CMD;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                PH_CMD: begin
                  sda_oe   <= 1'b1;
                  state    <= S_ACK;
                  cmd_mask <= cmd_to_mask(shreg);
                  phase    <= PH_DATA;
                end
                default: begin
                  sda_oe  <= 1'b1;
                  state   <= S_ACK;
                  phase   <= PH_CMD;
                  wr_stb  <= (cmd_mask != 2'b00);
                  wr_mask <= cmd_mask;
                  wr_val  <= clamped;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_read) begin
                txsh   <= tx_first;
                sda_oe <= ~tx_first[7];
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == LAST_TX) begin
                sda_oe <= 1'b0;
                state  <= S_TXACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                txsh   <= tx_next;
                sda_oe <= ~tx_next[7];
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/wiper_commit_regs.sv
module wiper_commit_regs #(
  parameter int CHANNELS = 2,
  parameter int POS_W    = 7,
  parameter int MUTE     = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_stb,
  input  logic [CHANNELS-1:0]              wr_mask,
  input  logic [POS_W-1:0]                 wr_val,
  input  logic [CHANNELS-1:0]              zc_i,
  output logic [CHANNELS-1:0][POS_W-1:0]   pos_o
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [POS_W-1:0] pend;
    logic             pend_vld;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend     <= POS_W'(MUTE);
        pend_vld <= 1'b0;
        pos_o[c] <= POS_W'(MUTE);
      end else begin
        if (zc_i[c] && pend_vld) begin
          pos_o[c] <= pend;
        end
        if (wr_stb && wr_mask[c]) begin
          pend     <= wr_val;
          pend_vld <= 1'b1;
        end else if (zc_i[c]) begin
          pend_vld <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/wiper_ctl_top.sv
module wiper_ctl_top #(
  parameter int         STEPS       = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b0101
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic [1:0] zc_i,
  output logic [6:0] wiper0_o,
  output logic [6:0] wiper1_o
);

  localparam int POS_W    = $clog2(STEPS + 1);
  localparam int MUTE     = STEPS;
  localparam int CHANNELS = 2;

  logic                           scl_rise;
  logic                           scl_fall;
  logic                           start_det;
  logic                           stop_det;
  logic                           sda_lvl;
  logic                           wr_stb;
  logic [1:0]                     wr_mask;
  logic [POS_W-1:0]               wr_val;
  logic [CHANNELS-1:0][POS_W-1:0] pos;

  wiper_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl)
  );

  wiper_serial_slave #(
    .POS_W       (POS_W),
    .MUTE        (MUTE),
    .ADDR_PREFIX (ADDR_PREFIX)
  ) u_slave (
    .clk       (clk),
    .rst       (rst),
    .strap_i   (strap_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl),
    .rd_pos0   (pos[0]),
    .rd_pos1   (pos[1]),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_mask   (wr_mask),
    .wr_val    (wr_val)
  );

  wiper_commit_regs #(
    .CHANNELS (CHANNELS),
    .POS_W    (POS_W),
    .MUTE     (MUTE)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_mask (wr_mask),
    .wr_val  (wr_val),
    .zc_i    (zc_i),
    .pos_o   (pos)
  );

  assign wiper0_o = 7'(pos[0]);
  assign wiper1_o = 7'(pos[1]);

endmodule

// File: rtl/wiper_ctl_checker.sv
module wiper_ctl_checker #(
  parameter int MUTE = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [1:0] zc_i,
  input logic [6:0] wiper0_o,
  input logic [6:0] wiper1_o
);

  localparam logic [6:0] MUTE_V = 7'(MUTE);

  a_r1_reset_mute: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wiper0_o == MUTE_V && wiper1_o == MUTE_V && !sda_oe));

  a_r4_range_w0: assert property (@(posedge clk) disable iff (rst)
    wiper0_o <= MUTE_V);

  a_r4_range_w1: assert property (@(posedge clk) disable iff (rst)
    wiper1_o <= MUTE_V);

  a_r5_hold_w0: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(zc_i[0])) |-> $stable(wiper0_o));

  a_r5_hold_w1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(zc_i[1])) |-> $stable(wiper1_o));

  a_r6_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (sda_oe != $past(sda_oe))) |-> !scl_i);

endmodule

bind wiper_ctl_top wiper_ctl_checker #(.MUTE(STEPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .zc_i     (zc_i),
  .wiper0_o (wiper0_o),
  .wiper1_o (wiper1_o)
);

// File: tb/wiper_ctl_tb.sv
module wiper_ctl_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;
  localparam int WATCHDOG   = 190000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b0101, STRAP, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b0101, STRAP, 1'b1};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [1:0] zc = 2'b00;
  logic [6:0] w0;
  logic [6:0] w1;

  int n_chk  = 0;
  int n_fail = 0;
  int m_com [2];
  int m_pend[2];
  bit m_vld [2];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  wiper_ctl_top dut_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .strap_i  (STRAP),
    .zc_i     (zc),
    .wiper0_o (w0),
    .wiper1_o (w1)
  );

  function automatic int clamp_f(input int d);
    return (d > 64) ? 64 : d;
  endfunction

  function automatic int mask_f(input logic [7:0] c);
    if (c == 8'hA9) return 1;
    if (c == 8'hAA) return 2;
    if (c == 8'hAF) return 3;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic bus_bit(input bit b, output bit seen);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    seen = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~give_ack, s);
    sda_m = 1'b1;
  endtask

  task automatic model_write(input logic [7:0] c, input int d);
    int m;
    m = mask_f(c);
    for (int k = 0; k < 2; k++)
      if (m[k]) begin
        m_pend[k] = clamp_f(d);
        m_vld[k]  = 1'b1;
      end
  endtask

  task automatic write_pair(input logic [7:0] c, input logic [7:0] d, input string req);
    bit a0, a1, a2;
    bus_start();
    send_byte(ADDR_W, a0);
    send_byte(c, a1);
    send_byte(d, a2);
    bus_stop();
    check({req, " R6 ack addr"}, a0, 1);
    check({req, " R6 ack cmd"}, a1, 1);
    check({req, " R6 ack data"}, a2, 1);
    model_write(c, d);
  endtask

  task automatic strobe(input logic [1:0] m);
    @(negedge clk);
    zc = m;
    @(negedge clk);
    zc = 2'b00;
    for (int k = 0; k < 2; k++)
      if (m[k] && m_vld[k]) begin
        m_com[k] = m_pend[k];
        m_vld[k] = 1'b0;
      end
    @(negedge clk);
  endtask

  task automatic cmp_outs(input string req);
    check({req, " wiper0"}, w0, m_com[0]);
    check({req, " wiper1"}, w1, m_com[1]);
  endtask

  task automatic read_back(input string req);
    logic [7:0] b0, b1, b2;
    bit a;
    bus_start();
    send_byte(ADDR_R, a);
    check({req, " R2 read addr ack"}, a, 1);
    recv_byte(1'b1, b0);
    recv_byte(1'b1, b1);
    recv_byte(1'b0, b2);
    check({req, " R8 sda released after nack"}, sda_oe, 0);
    bus_stop();
    check({req, " R7 first byte wiper0"}, b0, m_com[0]);
    check({req, " R7 second byte wiper1"}, b1, m_com[1]);
    check({req, " R7 extra byte repeats wiper1"}, b2, m_com[1]);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit a0, a1, a2, a3;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 2; k++) begin
      m_com[k] = 64; m_pend[k] = 64; m_vld[k] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 wiper0 reset", w0, 64);
    check("R1 wiper1 reset", w1, 64);
    check("R1 sda released", sda_oe, 0);

    // R3 R5 single wiper pending until its own strobe
    write_pair(8'hA9, 8'd10, "R3 w0");
    check("R5 w0 held before strobe", w0, 64);
    strobe(2'b10);
    check("R5 other strobe no effect", w0, 64);
    strobe(2'b01);
    check("R5 R3 w0 committed", w0, 10);
    cmp_outs("R5 after commit");

    // R3 both wipers
    write_pair(8'hAF, 8'd30, "R3 both");
    strobe(2'b11);
    check("R3 both w0", w0, 30);
    check("R3 both w1", w1, 30);

    // R4 clamp
    write_pair(8'hAA, 8'd200, "R4 200");
    strobe(2'b10);
    check("R4 200 clamps", w1, 64);
    write_pair(8'hA9, 8'd65, "R4 65");
    strobe(2'b01);
    check("R4 65 clamps", w0, 64);
    write_pair(8'hA9, 8'd64, "R4 64");
    write_pair(8'hAA, 8'd63, "R4 63");
    strobe(2'b11);
    check("R4 64 kept", w0, 64);
    check("R4 63 kept", w1, 63);

    // R2 foreign address ignored
    bus_start();
    send_byte({4'b0101, ~STRAP, 1'b0}, a0);
    send_byte(8'hAF, a1);
    send_byte(8'd5, a2);
    bus_stop();
    check("R2 foreign addr nack", a0, 0);
    check("R2 ignored cmd nack", a1, 0);
    check("R2 ignored data nack", a2, 0);
    strobe(2'b11);
    cmp_outs("R2 foreign write no effect");

    // R7 read returns committed, not pending
    write_pair(8'hA9, 8'd7, "R7 pend");
    read_back("R7 pending hidden");
    strobe(2'b01);
    read_back("R7 after commit");

    // R9 several pairs in one transfer
    bus_start();
    send_byte(ADDR_W, a0);
    send_byte(8'hA9, a1);
    send_byte(8'd3, a2);
    send_byte(8'hAA, a3);
    check("R9 second cmd ack", a3, 1);
    send_byte(8'd4, a3);
    check("R9 second data ack", a3, 1);
    bus_stop();
    model_write(8'hA9, 3);
    model_write(8'hAA, 4);
    strobe(2'b11);
    check("R9 w0", w0, 3);
    check("R9 w1", w1, 4);

    // R10 repeated start drops half command
    bus_start();
    send_byte(ADDR_W, a0);
    send_byte(8'hA9, a1);
    bus_start();
    send_byte(ADDR_W, a2);
    check("R10 addr ack after restart", a2, 1);
    send_byte(8'hAA, a3);
    send_byte(8'd9, a3);
    bus_stop();
    model_write(8'hAA, 9);
    strobe(2'b11);
    check("R10 w0 untouched", w0, 3);
    check("R10 w1 written", w1, 9);

    // R11 unknown command
    write_pair(8'h55, 8'd20, "R11 unknown");
    strobe(2'b11);
    check("R11 w0 unchanged", w0, 3);
    check("R11 w1 unchanged", w1, 9);

    // random mix against the model (R3 R4 R5 R7)
    for (int it = 0; it < 30; it++) begin
      int op;
      op = $urandom % 3;
      if (op == 0) begin
        logic [7:0] c;
        int sel;
        sel = $urandom % 3;
        c = (sel == 0) ? 8'hA9 : (sel == 1) ? 8'hAA : 8'hAF;
        write_pair(c, 8'($urandom), "R3 random write");
      end else if (op == 1) begin
        strobe(2'($urandom));
      end else begin
        read_back("R7 random read");
      end
      cmp_outs("R5 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule